// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block is the transmit store between a processor and an audio codec link. Software-side logic hands it 32-bit data words. Each word becomes one 20-bit sample, or two of them, with the sample's most significant bit moved up to bit 19. The block keeps the samples in a circular buffer. When the link is enabled it hands them on as left/right pairs over a valid/ready handshake toward the codec-side framer.

A set of live control inputs sets how words are converted and when draining may run: a transmit enable, a two-bit sample-width code, a compact-packing request and the selection of the two audio data slots. Four status flags follow the occupancy: empty, half-empty, full and underrun. They change only on writes and on drains, under the rules below. The depth is a power-of-two parameter.

Top module: `audio_tx_fifo`

## Requirements
- R1: In non-compact mode each write stores one sample, computed as `(wr_data << shift)` masked to 20 bits. The width code sets the shift: code 0 is 16-bit (shift 4), code 1 is 18-bit (shift 2), code 2 is 20-bit (shift 0) and code 3 is 12-bit (shift 8).
- R2: In compact mode (width code 0 or 3 with `compact_req` high) a write stores two samples. `wr_data[15:0]` is stored first and `wr_data[31:16]` second. Each half is shifted left by 8 for code 3 and by 4 for code 0, then truncated to 20 bits.
- R3: When `compact_req` is high with width code 1 or 2, compact packing is ignored and the write is handled as in R1.
- R4: A non-compact write is dropped when `level` equals DEPTH. A compact write is accepted only when `level`+2 < DEPTH; otherwise it is dropped. A dropped write leaves the contents and `level` unchanged.
- R5: `pair_valid` is low unless `tx_en` is high, `slot_sel` is nonzero and `level` ≥ 2. A new drain burst starts only when `level` ≥ DEPTH/2.
- R6: `pair_data[39:20]` holds the older sample (left) and `pair_data[19:0]` the next one (right). Each cycle with `pair_valid` and `pair_ready` both high removes those two samples. After a transfer the burst goes on while at least two samples remain. A cycle with valid high and ready low ends the burst.
- R7: On a write request, with L the level after the write: L > 0 clears empty and underrun, L ≥ DEPTH/2 clears half-empty, and L = DEPTH sets full.
- R8: On a pair transfer, with L the resulting level: full is cleared, L ≤ DEPTH/2 sets half-empty, and L = 0 sets empty and underrun. These rules are applied after those of R7 in the same cycle.
- R9: After reset `level` is 0, empty and half-empty are set, full and underrun are clear, and `pair_valid` is low.
- R10: `level` reports the number of stored samples one cycle after each write or transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for `wr_data` |
| wr_data | input | 32 | Data word to convert and store |
| tx_en | input | 1 | Transmit enable |
| width_code | input | 2 | Sample width: 0=16, 1=18, 2=20, 3=12 bits |
| compact_req | input | 1 | Request two 16-bit samples per word |
| slot_sel | input | 2 | Audio data slot selection; any set bit allows draining |
| pair_ready | input | 1 | Codec side accepts a pair this cycle |
| pair_valid | output | 1 | A left/right pair is offered |
| pair_data | output | 40 | Left sample in [39:20], right sample in [19:0] |
| flag_empty | output | 1 | Empty status flag |
| flag_half | output | 1 | Half-empty status flag |
| flag_full | output | 1 | Full status flag |
| flag_underrun | output | 1 | Underrun status flag |
| level | output | clog2(DEPTH)+1 | Stored sample count |

## Verification
The properties assume only that the control inputs and `pair_ready` are legal binary values, which may change on any cycle. `pair_ready` may be raised without waiting for `pair_valid` and may be dropped in the middle of a burst. The stimulus therefore changes width, compaction, slots, enable and ready freely from cycle to cycle. Directed sequences drive the buffer to exact full, to the compact-admission edge and to bursts that are cut short by the codec. The reset between directed sequences is the only time the inputs are held in a fixed pattern.

// File: rtl/atf_pkg.sv
package atf_pkg;
   localparam int SAMPLE_W = 20;
   localparam int WORD_W   = 32;
   localparam int HALF_W   = 16;

   typedef logic [SAMPLE_W-1:0] sample_t;

   typedef enum logic [1:0] {
      WC_16 = 2'd0,
      WC_18 = 2'd1,
      WC_20 = 2'd2,
      WC_12 = 2'd3
   } width_code_e;

   // left shift that puts a sample's MSB at bit 19 (non-compact)
   function automatic logic [4:0] loose_shift(width_code_e wc);
      case (wc)
         WC_12:   return 5'd8;
         WC_16:   return 5'd4;
         WC_18:   return 5'd2;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic packing_legal(width_code_e wc);
      return (wc == WC_16) || (wc == WC_12);
   endfunction
endpackage

// File: rtl/atf_sample_packer.sv
module atf_sample_packer
   import atf_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        width_code,
   input  logic              compact_req,
   output logic              is_pair,
   output sample_t           samp0,
   output sample_t           samp1
);
   width_code_e        wc;
   logic [4:0]         nc_shift;
   logic [4:0]         c_shift;
   logic [WORD_W-1:0]  nc_word;
   sample_t            half_s [2];

   assign wc       = width_code_e'(width_code);
   assign nc_shift = loose_shift(wc);
   assign c_shift  = (wc == WC_12) ? 5'd8 : 5'd4;
   assign is_pair  = compact_req && packing_legal(wc);
   assign nc_word  = word << nc_shift;

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [SAMPLE_W+HALF_W-1:0] wide;
      assign wide      = {{SAMPLE_W{1'b0}}, word[HALF_W*h +: HALF_W]} << c_shift;
      assign half_s[h] = wide[SAMPLE_W-1:0];
   end

   assign samp0 = is_pair ? half_s[0] : nc_word[SAMPLE_W-1:0];
   assign samp1 = half_s[1];
endmodule

// File: rtl/atf_ring.sv
module atf_ring
   import atf_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          is_pair,
   input  sample_t       din0,
   input  sample_t       din1,
   input  logic          pop_pair,
   output logic          accepted,
   output sample_t       dout0,
   output sample_t       dout1,
   output logic [LW-1:0] level,
   output logic [LW-1:0] level_wr,
   output logic [LW-1:0] level_nx
);
   sample_t        mem [DEPTH];
   logic [AW-1:0]  wp, rp, wp_n1, rp_n1;
   logic [LW-1:0]  push_cnt;
   logic           room;

   assign room     = is_pair ? ((int'(level) + 2) < DEPTH) : (int'(level) < DEPTH);
   assign accepted = wr_req && room;
   assign push_cnt = !accepted ? LW'(0) : (is_pair ? LW'(2) : LW'(1));
   assign level_wr = level + push_cnt;
   assign level_nx = level_wr - (pop_pair ? LW'(2) : LW'(0));

   assign wp_n1 = wp + 1'b1;
   assign rp_n1 = rp + 1'b1;
   assign dout0 = mem[rp];
   assign dout1 = mem[rp_n1];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (accepted && (wp == AW'(i)))
            mem[i] <= din0;
         else if (accepted && is_pair && (wp_n1 == AW'(i)))
            mem[i] <= din1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         wp    <= wp + AW'(push_cnt);
         if (pop_pair)
            rp <= rp + AW'(2);
         level <= level_nx;
      end
   end
endmodule

// File: rtl/atf_drain_ctl.sv
module atf_drain_ctl #(
   parameter  int DEPTH = 8,
   localparam int LW    = $clog2(DEPTH) + 1,
   localparam int HALF  = DEPTH / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en,
   input  logic [1:0]    slot_sel,
   input  logic [LW-1:0] level,
   input  logic          pair_ready,
   output logic          pair_valid,
   output logic          fire
);
   logic burst_q;
   logic go, enough, start;

   assign go         = tx_en && (|slot_sel);
   assign enough     = level >= LW'(2);
   assign start      = level >= LW'(HALF);
   assign pair_valid = go && enough && (start || burst_q);
   assign fire       = pair_valid && pair_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) burst_q <= 1'b0;
      else        burst_q <= fire;
   end
endmodule

// File: rtl/atf_status.sv
module atf_status #(
   parameter  int DEPTH = 8,
   localparam int LW    = $clog2(DEPTH) + 1,
   localparam int HALF  = DEPTH / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [LW-1:0] level_wr,
   input  logic          fire,
   input  logic [LW-1:0] level_nx,
   output logic          flag_empty,
   output logic          flag_half,
   output logic          flag_full,
   output logic          flag_underrun
);
   logic e_d, h_d, f_d, u_d;

   always_comb begin
      e_d = flag_empty;
      h_d = flag_half;
      f_d = flag_full;
      u_d = flag_underrun;
      if (wr_req) begin
         if (level_wr != '0) begin
            e_d = 1'b0;
            u_d = 1'b0;
         end
         if (level_wr >= LW'(HALF))  h_d = 1'b0;
         if (level_wr >= LW'(DEPTH)) f_d = 1'b1;
      end
      if (fire) begin
         f_d = 1'b0;
         if (level_nx <= LW'(HALF)) h_d = 1'b1;
         if (level_nx == '0) begin
            e_d = 1'b1;
            u_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_empty    <= 1'b1;
         flag_half     <= 1'b1;
         flag_full     <= 1'b0;
         flag_underrun <= 1'b0;
      end else begin
         flag_empty    <= e_d;
         flag_half     <= h_d;
         flag_full     <= f_d;
         flag_underrun <= u_d;
      end
   end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
   import atf_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int LW    = $clog2(DEPTH) + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [31:0]            wr_data,
   input  logic                   tx_en,
   input  logic [1:0]             width_code,
   input  logic                   compact_req,
   input  logic [1:0]             slot_sel,
   input  logic                   pair_ready,
   output logic                   pair_valid,
   output logic [2*SAMPLE_W-1:0]  pair_data,
   output logic                   flag_empty,
   output logic                   flag_half,
   output logic                   flag_full,
   output logic                   flag_underrun,
   output logic [LW-1:0]          level
);
   if (DEPTH < 8 || DEPTH > 2048 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("audio_tx_fifo: DEPTH must be a power of two from 8 to 2048");
   end

   logic          is_pair, accepted, fire;
   sample_t       samp0, samp1, dout0, dout1;
   logic [LW-1:0] level_wr, level_nx;

   atf_sample_packer u_packer (
      .word        (wr_data),
      .width_code  (width_code),
      .compact_req (compact_req),
      .is_pair     (is_pair),
      .samp0       (samp0),
      .samp1       (samp1)
   );

   atf_ring #(.DEPTH(DEPTH)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_en),
      .is_pair  (is_pair),
      .din0     (samp0),
      .din1     (samp1),
      .pop_pair (fire),
      .accepted (accepted),
      .dout0    (dout0),
      .dout1    (dout1),
      .level    (level),
      .level_wr (level_wr),
      .level_nx (level_nx)
   );

   atf_drain_ctl #(.DEPTH(DEPTH)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_en),
      .slot_sel   (slot_sel),
      .level      (level),
      .pair_ready (pair_ready),
      .pair_valid (pair_valid),
      .fire       (fire)
   );

   atf_status #(.DEPTH(DEPTH)) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_req        (wr_en),
      .level_wr      (level_wr),
      .fire          (fire),
      .level_nx      (level_nx),
      .flag_empty    (flag_empty),
      .flag_half     (flag_half),
      .flag_full     (flag_full),
      .flag_underrun (flag_underrun)
   );

   assign pair_data = {dout0, dout1};

   logic unused_ok;
   assign unused_ok = accepted;
endmodule

// File: rtl/atf_checker.sv
module atf_checker #(
   parameter  int DEPTH = 8,
   localparam int LW    = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          tx_en,
   input logic [1:0]    slot_sel,
   input logic          pair_valid,
   input logic          pair_ready,
   input logic          flag_empty,
   input logic          flag_full,
   input logic          flag_underrun,
   input logic [LW-1:0] level
);
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   a_r5_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> (tx_en && slot_sel != 2'b00));

   a_r5_valid_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> level >= LW'(2));

   a_r7_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(pair_valid && pair_ready)) |=> !flag_empty);

   a_r8_last_pair_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid && pair_ready && level == LW'(2) && !wr_en) |=> (flag_empty && flag_underrun));

   a_r8_empty_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flag_empty |-> level == '0);

   a_r7_full_means_depth: assert property (@(posedge clk) disable iff (!rst_n)
      flag_full |-> level == LW'(DEPTH));

   a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(pair_valid && pair_ready)) |=> $stable(level));
endmodule

bind audio_tx_fifo atf_checker #(.DEPTH(DEPTH)) i_atf_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .tx_en         (tx_en),
   .slot_sel      (slot_sel),
   .pair_valid    (pair_valid),
   .pair_ready    (pair_ready),
   .flag_empty    (flag_empty),
   .flag_full     (flag_full),
   .flag_underrun (flag_underrun),
   .level         (level)
);

// File: tb/test_audio_tx_fifo.sv
module test_audio_tx_fifo;
   localparam int DEPTH = 8;
   localparam int HALF  = DEPTH / 2;
   localparam int LW    = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic          tx_en = 1'b0;
   logic [1:0]    width_code = '0;
   logic          compact_req = 1'b0;
   logic [1:0]    slot_sel = '0;
   logic          pair_ready = 1'b0;
   logic          pair_valid;
   logic [39:0]   pair_data;
   logic          flag_empty, flag_half, flag_full, flag_underrun;
   logic [LW-1:0] level;

   always #2 clk = ~clk;

   audio_tx_fifo #(.DEPTH(DEPTH)) i_audio_tx_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
      .width_code(width_code), .compact_req(compact_req), .slot_sel(slot_sel),
      .pair_ready(pair_ready), .pair_valid(pair_valid), .pair_data(pair_data),
      .flag_empty(flag_empty), .flag_half(flag_half), .flag_full(flag_full),
      .flag_underrun(flag_underrun), .level(level)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [19:0] mq[$];
   bit m_e, m_h, m_f, m_u, m_burst;

   function automatic logic [19:0] conv_loose(logic [31:0] w, logic [1:0] wc);
      logic [31:0] t;
      case (wc)
         2'd3: t = w << 8;
         2'd0: t = w << 4;
         2'd1: t = w << 2;
         default: t = w;
      endcase
      return t[19:0];
   endfunction

   function automatic logic [19:0] conv_half(logic [15:0] hf, logic [1:0] wc);
      logic [35:0] t;
      t = {20'b0, hf} << ((wc == 2'd3) ? 8 : 4);
      return t[19:0];
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      mq.delete();
      m_e = 1; m_h = 1; m_f = 0; m_u = 0; m_burst = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; wr_en = 0; tx_en = 0; pair_ready = 0; compact_req = 0; slot_sel = 0;
      @(posedge clk); @(negedge clk);
      rst_n = 1;
      model_clear();
      chk("R9", "flags", {60'd0, flag_empty, flag_half, flag_full, flag_underrun}, 64'b1100);
      chk("R9", "level", 64'(level), 64'd0);
      chk("R9", "pair_valid", 64'(pair_valid), 64'd0);
   endtask

   // called at a negedge; drives one cycle and checks around it
   task automatic step(bit wr, logic [31:0] d, bit en, logic [1:0] wc, bit cmp,
                       logic [1:0] sl, bit rdy, string tag);
      int  sz;
      bit  v, fire, eff;
      wr_en = wr; wr_data = d; tx_en = en; width_code = wc; compact_req = cmp;
      slot_sel = sl; pair_ready = rdy;
      #1;
      sz = mq.size();
      v = en && (sl != 2'b00) && sz >= 2 && (sz >= HALF || m_burst);
      chk("R5 R6", "pair_valid", 64'(pair_valid), 64'(v));
      if (v) chk(tag, "pair_data", 64'(pair_data), 64'({mq[0], mq[1]}));
      fire = v && rdy;
      if (wr) begin
         eff = cmp && (wc == 2'd0 || wc == 2'd3);
         if (eff) begin
            if (sz + 2 < DEPTH) begin
               mq.push_back(conv_half(d[15:0], wc));
               mq.push_back(conv_half(d[31:16], wc));
            end
         end else if (sz < DEPTH) begin
            mq.push_back(conv_loose(d, wc));
         end
         if (mq.size() != 0) begin m_e = 0; m_u = 0; end
         if (mq.size() >= HALF) m_h = 0;
         if (mq.size() >= DEPTH) m_f = 1;
      end
      if (fire) begin
         void'(mq.pop_front());
         void'(mq.pop_front());
         m_f = 0;
         if (mq.size() <= HALF) m_h = 1;
         if (mq.size() == 0) begin m_e = 1; m_u = 1; end
      end
      m_burst = fire;
      @(posedge clk); @(negedge clk);
      chk((tag == "R6") ? "R10" : tag, "level", 64'(level), 64'(mq.size()));
      chk("R7 R8", "flags {empty,half,full,underrun}",
          {60'd0, flag_empty, flag_half, flag_full, flag_underrun},
          {60'd0, m_e, m_h, m_f, m_u});
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7719));
      repeat (3) @(posedge clk);
      @(negedge clk);
      do_reset();

      // R1: each width code, non-compact placement
      for (int wc = 0; wc < 4; wc++) begin
         do_reset();
         for (int k = 0; k < 4; k++) step(1, $urandom, 0, 2'(wc), 0, 2'b01, 0, "R1");
         for (int k = 0; k < 2; k++) step(0, 0, 1, 2'(wc), 0, 2'b01, 1, "R1");
      end
      // R2: compact split, low half first
      for (int j = 0; j < 2; j++) begin
         do_reset();
         for (int k = 0; k < 2; k++) step(1, $urandom, 0, (j == 0) ? 2'd0 : 2'd3, 1, 2'b11, 0, "R2");
         for (int k = 0; k < 2; k++) step(0, 0, 1, 2'd0, 0, 2'b11, 1, "R2");
      end
      // R3: compact request ignored for 18/20-bit
      for (int j = 1; j < 3; j++) begin
         do_reset();
         for (int k = 0; k < 4; k++) step(1, $urandom, 0, 2'(j), 1, 2'b10, 0, "R3");
         for (int k = 0; k < 2; k++) step(0, 0, 1, 2'(j), 1, 2'b10, 1, "R3");
      end
      // R4: exact full, drop, compact admission edge
      do_reset();
      for (int k = 0; k < DEPTH + 1; k++) step(1, $urandom, 0, 2'd2, 0, 2'b01, 1, "R4");
      do_reset();
      for (int k = 0; k < 4; k++) step(1, $urandom, 0, 2'd0, 1, 2'b01, 0, "R4");
      step(1, $urandom, 0, 2'd3, 1, 2'b01, 0, "R4");
      step(1, $urandom, 0, 2'd2, 0, 2'b01, 0, "R4");
      // R5: gating by slots, enable and start threshold
      step(0, 0, 1, 2'd0, 0, 2'b00, 1, "R5");
      step(0, 0, 0, 2'd0, 0, 2'b11, 1, "R5");
      do_reset();
      for (int k = 0; k < 3; k++) step(1, $urandom, 1, 2'd1, 0, 2'b01, 1, "R5");
      step(0, 0, 1, 2'd1, 0, 2'b01, 1, "R5");
      // R6: burst continuation and interruption by the codec
      do_reset();
      for (int k = 0; k < DEPTH; k++) step(1, $urandom, 0, 2'd2, 0, 2'b10, 1, "R6");
      step(0, 0, 1, 2'd2, 0, 2'b10, 1, "R6");
      step(0, 0, 1, 2'd2, 0, 2'b10, 0, "R6");
      step(0, 0, 1, 2'd2, 0, 2'b10, 1, "R6");
      step(0, 0, 1, 2'd2, 0, 2'b10, 1, "R6");
      step(0, 0, 1, 2'd2, 0, 2'b10, 1, "R6");
      step(0, 0, 1, 2'd2, 0, 2'b10, 1, "R6");
      // mixed random traffic
      do_reset();
      for (int n = 0; n < 6000; n++) begin
         step(($urandom % 10) < 6, $urandom, ($urandom % 4) != 0, 2'($urandom),
              1'($urandom), 2'($urandom), ($urandom % 10) < 7, "R6");
         if (n == 3000) do_reset();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule